// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a synchronous host read and write one external asynchronous static RAM of 8,192 words of 8 bits. The host raises a request together with a write flag, a 13-bit word address and, for writes, a data byte. The controller runs one timed access on the memory pins and then returns a one-cycle completion pulse. A read also returns the byte it fetched.

On the memory side the controller drives the address and two chip selects of opposite sense: one active low and one active high. It also drives an active-low write strobe, an active-low output enable and the three signals of a split bidirectional data bus. Every minimum time of the memory is a parameter in picoseconds. Each is turned into a whole number of clock cycles by rounding up at the configured clock period. The sequencing keeps the controller's data driver and the memory's output drivers from ever being on in the same cycle.

Top module: `sram_ctl`

## Requirements
- R1: While no access is running, and from reset, the pins rest in standby: the low-active select is 1, the high-active select is 0, the write strobe and the output enable are 1, the data driver enable is 0 and the completion pulse is 0.
- R2: A read holds both selects active, output enable at 0 and write strobe at 1, with a stable address, for RD_CYC cycles. RD_CYC is the largest of the access time, the output-enable access time and the read cycle time, each rounded up to cycles (25 at 250 MHz).
- R3: The read byte is sampled from the data input on the last cycle of the read window. It is presented on the read-data output together with the completion pulse and stays unchanged until the next completion.
- R4: A write holds both selects active and the write strobe at 0 for WR_CYC cycles, with output enable held at 1 throughout. The byte the host gave is the byte the memory latches.
- R5: The data driver turns on only after the write strobe has been low for WHZ_CYC cycles (the memory's output-off delay, rounded up). It stays on for at least DS_CYC cycles (the data setup time) and turns off on the same clock edge that raises the write strobe.
- R6: The write strobe is low for at least the write pulse width, and both selects are active for at least the address-valid-to-end time and the write cycle time, each rounded up to cycles.
- R7: Between two accesses the selects spend at least one cycle inactive.
- R8: A request is taken only when the controller is idle. Changes to the request's address, data or write flag while an access runs have no effect on that access, and a dropped request starts nothing.
- R9: Each access yields exactly one completion pulse, one cycle wide.
- R10: The data driver is never enabled while the memory is selected with output enable low and write strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Access request, taken when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Last read byte, held until next completion |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_a | output | 13 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The bench builds the controller with its default timing: a 4 ns period and the memory's 100 ns grade. At that setting a read spans 25 cycles, the output-off wait spans 9 cycles and the driver stays on for 16 cycles before the strobe rises. Because these windows are many cycles long, sampling one cycle early, enabling the driver one cycle early or releasing it one edge late all show up at the pins. The memory model returns a poison byte until the full access time has elapsed, so a read window that is too short returns a wrong byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_GAP   = 2'd3
  } sram_st_e;

  // Whole clock cycles needed to cover t_ps, rounded up.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rstsync.sv
module sram_ctl_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = CNT_W'(1);
    else if (en) cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 25,
  parameter int unsigned WR_CYC  = 25,
  parameter int unsigned WHZ_CYC = 9,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [CNT_W-1:0] cnt,
  output logic             start,
  output logic             run,
  output logic             cap,
  output logic             done,
  output logic             cs1_n,
  output logic             cs2,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);
  sram_st_e st_q, st_d;
  logic     fin;
  logic     sel_d, we_n_d, oe_n_d, dq_oe_d;

  // next state
  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    fin   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          start = 1'b1;
          st_d  = req_we ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        if (cnt == CNT_W'(RD_CYC)) begin
          fin  = 1'b1;
          st_d = ST_GAP;
        end
      end
      ST_WRITE: begin
        if (cnt == CNT_W'(WR_CYC)) begin
          fin  = 1'b1;
          st_d = ST_GAP;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // pin levels for the coming cycle
  always_comb begin
    sel_d   = (st_d == ST_READ) || (st_d == ST_WRITE);
    we_n_d  = (st_d != ST_WRITE);
    oe_n_d  = (st_d != ST_READ);
    dq_oe_d = (st_q == ST_WRITE) && (st_d == ST_WRITE) && (cnt >= CNT_W'(WHZ_CYC));
  end

  assign run = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign cap = fin && (st_q == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cs1_n <= 1'b1;
      cs2   <= 1'b0;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cs1_n <= ~sel_d;
      cs2   <= sel_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      dq_oe <= dq_oe_d;
      done  <= fin;
    end
  end
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_we,
  input  logic              cap,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_a,
  output logic [DATA_W-1:0] mem_dout,
  output logic [DATA_W-1:0] rdata
);
  logic wr_load;

  assign wr_load = start && start_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_a    <= '0;
      mem_dout <= '0;
      rdata    <= '0;
    end else begin
      if (start)   mem_a    <= req_addr;
      if (wr_load) mem_dout <= req_wdata;
      if (cap)     rdata    <= mem_din;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_RC_PS   = 100000,
  parameter int unsigned T_ACC_PS  = 100000,
  parameter int unsigned T_OE_PS   = 50000,
  parameter int unsigned T_WC_PS   = 100000,
  parameter int unsigned T_WP_PS   = 60000,
  parameter int unsigned T_AW_PS   = 80000,
  parameter int unsigned T_DS_PS   = 50000,
  parameter int unsigned T_WHZ_PS  = 35000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] mem_a,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned RD_CYC  = umax(umax(ps_to_cyc(T_ACC_PS, CLK_PS),
                                              ps_to_cyc(T_RC_PS, CLK_PS)),
                                         umax(ps_to_cyc(T_OE_PS, CLK_PS), 1));
  localparam int unsigned WHZ_CYC = umax(ps_to_cyc(T_WHZ_PS, CLK_PS), 1);
  localparam int unsigned DS_CYC  = umax(ps_to_cyc(T_DS_PS, CLK_PS), 1);
  localparam int unsigned WR_CYC  = umax(umax(ps_to_cyc(T_WP_PS, CLK_PS),
                                              ps_to_cyc(T_AW_PS, CLK_PS)),
                                         umax(ps_to_cyc(T_WC_PS, CLK_PS), WHZ_CYC + DS_CYC));
  localparam int unsigned CNT_W   = $clog2(umax(RD_CYC, WR_CYC) + 1);

  logic             srst_n;
  logic             start, run, cap;
  logic [CNT_W-1:0] cnt;

  sram_ctl_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (srst_n),
    .clr   (start),
    .en    (run),
    .cnt   (cnt)
  );

  sram_ctl_seq #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .WHZ_CYC (WHZ_CYC),
    .CNT_W   (CNT_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (srst_n),
    .req    (req),
    .req_we (req_we),
    .cnt    (cnt),
    .start  (start),
    .run    (run),
    .cap    (cap),
    .done   (rsp_done),
    .cs1_n  (mem_cs1_n),
    .cs2    (mem_cs2),
    .we_n   (mem_we_n),
    .oe_n   (mem_oe_n),
    .dq_oe  (mem_dq_oe)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (srst_n),
    .start     (start),
    .start_we  (req_we),
    .cap       (cap),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_din   (mem_dq_in),
    .mem_a     (mem_a),
    .mem_dout  (mem_dq_out),
    .rdata     (rsp_rdata)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_a,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n));

  // R4
  write_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));

  // R2
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_cs1_n && mem_cs2));

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs2 && $past(mem_cs2)) |-> $stable(mem_a));

  // R5
  drv_late_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> !$past(mem_we_n));

  // R5
  drv_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_dq_oe) |-> $rose(mem_we_n));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_done);

  // R7
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs2) |=> !mem_cs2);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_rdata (rsp_rdata),
  .rsp_done  (rsp_done),
  .mem_a     (mem_a),
  .mem_cs1_n (mem_cs1_n),
  .mem_cs2   (mem_cs2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;
  localparam int CLK_PS   = 4000;
  localparam int RD_NEED  = (100000 + CLK_PS - 1) / CLK_PS;
  localparam int WP_NEED  = (60000 + CLK_PS - 1) / CLK_PS;
  localparam int AW_NEED  = (80000 + CLK_PS - 1) / CLK_PS;
  localparam int WC_NEED  = (100000 + CLK_PS - 1) / CLK_PS;
  localparam int DS_NEED  = (50000 + CLK_PS - 1) / CLK_PS;
  localparam int WHZ_NEED = (35000 + CLK_PS - 1) / CLK_PS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata;
  logic        rsp_done;
  logic [12:0] mem_a;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sram_ctl u_sram_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .req_we     (req_we),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .rsp_done   (rsp_done),
    .mem_a      (mem_a),
    .mem_cs1_n  (mem_cs1_n),
    .mem_cs2    (mem_cs2),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .mem_dq_in  (mem_dq_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  // memory model contents and bench expectation, kept apart
  logic [7:0] mem_m [int];
  logic [7:0] exp_m [int];

  function automatic logic [7:0] mem_rd(input logic [12:0] a);
    return mem_m.exists(int'(a)) ? mem_m[int'(a)] : init_val(a);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [12:0] a);
    return exp_m.exists(int'(a)) ? exp_m[int'(a)] : init_val(a);
  endfunction

  // pin monitor and memory model, sampled mid-cycle
  int          wlo = 0, wdrv = 0, wpre = 0, rage = 0, idle_run = 0;
  logic        prev_wr = 1'b0, prev_rd = 1'b0, prev_sel = 1'b0, prev_drv = 1'b0;
  logic        seen_op = 1'b0, oe_bad = 1'b0, addr_bad = 1'b0, clash = 1'b0, we_bad = 1'b0;
  logic [12:0] prev_a = '0;
  logic [7:0]  last_dout = '0;

  always @(negedge clk) begin
    logic sel, drv;
    if (rst_n) begin
      sel = !mem_cs1_n && mem_cs2;
      drv = sel && !mem_oe_n && mem_we_n;
      if (mem_dq_oe && (drv || !sel)) clash = 1'b1;
      if (!mem_oe_n && !mem_we_n) we_bad = 1'b1;
      if (sel && prev_sel && mem_a != prev_a) addr_bad = 1'b1;
      // write tracking
      if (sel && !mem_we_n) begin
        wlo++;
        if (mem_dq_oe) begin
          wdrv++;
          last_dout = mem_dq_out;
        end else if (wdrv == 0) begin
          wpre++;
        end
        if (!mem_oe_n) oe_bad = 1'b1;
      end else if (prev_wr) begin
        chk("R6 strobe low cycles >= pulse width", 32'(wlo >= WP_NEED), 1);
        chk("R6 select cycles >= address-valid time", 32'(wlo >= AW_NEED), 1);
        chk("R6 write cycles >= write cycle time", 32'(wlo >= WC_NEED), 1);
        chk("R5 driver waits output-off delay", 32'(wpre >= WHZ_NEED), 1);
        chk("R5 driver on for data setup", 32'(wdrv >= DS_NEED), 1);
        chk("R5 driver on at latch", 32'(prev_drv), 1);
        chk("R5 driver off with strobe rise", 32'(mem_dq_oe), 0);
        mem_m[int'(prev_a)] = last_dout;
        wlo = 0; wdrv = 0; wpre = 0;
      end
      // read tracking
      if (drv) rage++;
      else if (prev_rd) begin
        chk("R2 read window length", 32'(rage >= RD_NEED), 1);
        rage = 0;
      end
      mem_dq_in = (drv && rage >= RD_NEED) ? mem_rd(mem_a) : 8'hEE;
      // gap between accesses
      if (sel && !prev_sel && seen_op)
        chk("R7 idle cycle before access", 32'(idle_run >= 1), 1);
      if (sel) begin
        seen_op = 1'b1;
        idle_run = 0;
      end else begin
        idle_run++;
      end
      prev_wr  = sel && !mem_we_n;
      prev_rd  = drv;
      prev_sel = sel;
      prev_a   = mem_a;
      prev_drv = mem_dq_oe;
    end
  end

  task automatic do_op(input logic w, input logic [12:0] a, input logic [7:0] d,
                       input logic scramble);
    int cyc;
    logic [7:0] got;
    cyc = 0;
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    while (!rsp_done && cyc < 200) begin
      cyc++;
      if (scramble && cyc == 6) begin
        req_we = !w; req_addr = a ^ 13'h1555; req_wdata = ~d;
      end
      @(negedge clk);
    end
    chk("R9 completion seen", 32'(rsp_done), 1);
    got = rsp_rdata;
    req = 1'b0;
    if (w) exp_m[int'(a)] = d;
    else   chk("R3 read data", 32'(got), 32'(exp_rd(a)));
    @(negedge clk);
    chk("R9 completion one cycle", 32'(rsp_done), 0);
    chk("R3 read data held", 32'(rsp_rdata), 32'(got));
    chk("R1 standby selects", {30'd0, mem_cs1_n, mem_cs2}, 32'b10);
  endtask

  initial begin
    logic [12:0] corner [4];
    int unused_seed;
    corner[0] = 13'h0000; corner[1] = 13'h1FFF; corner[2] = 13'h0AAA; corner[3] = 13'h1555;
    unused_seed = $urandom(32'd2718);
    repeat (4) @(negedge clk);
    chk("R1 reset cs1_n", 32'(mem_cs1_n), 1);
    chk("R1 reset cs2", 32'(mem_cs2), 0);
    chk("R1 reset we_n", 32'(mem_we_n), 1);
    chk("R1 reset oe_n", 32'(mem_oe_n), 1);
    chk("R1 reset driver", 32'(mem_dq_oe), 0);
    chk("R1 reset done", 32'(rsp_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // directed: reads of untouched words, write/read of both ends
    do_op(1'b0, 13'h0000, 8'h00, 1'b0);
    do_op(1'b1, 13'h0000, 8'h5A, 1'b0);
    do_op(1'b1, 13'h1FFF, 8'hA5, 1'b0);
    do_op(1'b0, 13'h1FFF, 8'h00, 1'b0);
    do_op(1'b0, 13'h0000, 8'h00, 1'b0);
    // R8: request fields changed mid-access
    do_op(1'b1, 13'h0123, 8'hC3, 1'b1);
    repeat (5) begin
      @(negedge clk);
      chk("R8 dropped request starts nothing", {30'd0, mem_cs2, rsp_done}, 0);
    end
    do_op(1'b0, 13'h0123, 8'h00, 1'b0);
    do_op(1'b0, 13'h0123 ^ 13'h1555, 8'h00, 1'b0);
    // R8: read whose flag flips to write mid-access
    do_op(1'b0, 13'h0777, 8'h11, 1'b1);
    do_op(1'b0, 13'h0777 ^ 13'h1555, 8'h00, 1'b0);
    // R4: write back-to-back then read
    do_op(1'b1, 13'h0042, 8'hFF, 1'b0);
    do_op(1'b1, 13'h0042, 8'h00, 1'b0);
    do_op(1'b0, 13'h0042, 8'h00, 1'b0);
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [12:0] a;
      logic        w;
      w = 1'($urandom % 2);
      if ($urandom % 3 == 0) a = corner[$urandom % 4];
      else                   a = 13'(($urandom % 16) * 511);
      do_op(w, a, 8'($urandom), 1'b0);
    end
    chk("R10 no driver overlap with memory output", 32'(clash), 0);
    chk("R2 address stable while selected", 32'(addr_bad), 0);
    chk("R2 strobe high while output enabled", 32'(we_bad), 0);
    chk("R4 output enable high during write", 32'(oe_bad), 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule